// File: doc/BRIEF.md
# Byte-Serial Word Packing Engine

This block sits between a 32-bit word FIFO and a card data path that moves one byte per transfer. Software programs a 16-bit transfer length, then writes an 8-bit control value whose enable bit starts the transfer. The control value's direction bit picks the path. In the card-to-host direction, arriving bytes are packed into little-endian words and pushed into the FIFO. In the host-to-card direction, words are popped from the FIFO and sent out byte by byte, least significant first.

A byte counter tracks the bytes still to move and is exported together with a rounded-up word count. Once the counter reaches zero, two sticky completion flags are raised. The enable bit clears itself once the counter is zero, the FIFO is empty and no outgoing byte is still waiting for the card. A final group of fewer than four bytes on the receive path is still pushed as a word, with zeros in its unused upper lanes.

Top module: `bytepack_engine`

## Requirements
- R1: After reset the control value, byte counter, word count, both completion flags, `tx_valid`, `rx_ready`, `fifo_push` and `fifo_pop` are all zero.
- R2: A control write stores all 8 bits, which read back on `ctl_rdata`. When bit 0 (enable) of the written value is 1, the byte counter loads from the last value written to the 16-bit length register. Bit 1 selects the direction (1 = card to host, 0 = host to card). Bits 2 and 3 are stored only.
- R3: Card to host: the first byte of each word lands in bits 7:0 and each later byte one lane higher. A word is pushed after every fourth byte.
- R4: Card to host: when the counter reaches zero with one to three bytes gathered, that partial word is pushed with zeros in the unfilled upper lanes.
- R5: Card to host: `rx_ready` is low while the FIFO reports full and while the counter is zero, so no byte beyond the programmed length is accepted.
- R6: Host to card: a word is popped only when the lane position is 0. Its bytes leave on `tx_data` starting with bits 7:0. `tx_data` holds steady while `tx_valid` is high and `tx_ready` is low.
- R7: The counter decrements by exactly one for each byte moved, and at most one byte moves per clock.
- R8: While enable is set and the counter is zero, `data_end` and `blk_end` are set on the next clock. They stay set until `stat_clr` is pulsed.
- R9: Enable clears itself one clock after the counter is zero, the FIFO is empty and no outgoing byte is pending. It stays set while the FIFO still holds words.
- R10: `word_cnt` equals (byte counter + 3) shifted right by 2.
- R11: A control write with bit 0 clear stops byte movement at once and leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write value (bit0 enable, bit1 direction, bit2 mode, bit3 DMA) |
| len_we | input | 1 | Length register write strobe |
| len_wdata | input | 16 | Transfer length in bytes |
| stat_clr | input | 1 | Clears both completion flags |
| ctl_rdata | output | 8 | Stored control value |
| byte_cnt | output | 16 | Bytes still to move |
| word_cnt | output | 15 | Rounded-up count of words still to move |
| data_end | output | 1 | Sticky transfer-complete flag |
| blk_end | output | 1 | Sticky block-complete flag |
| fifo_push | output | 1 | Push strobe into the word FIFO |
| fifo_wdata | output | 32 | Packed word to push |
| fifo_full | input | 1 | FIFO cannot take a word |
| fifo_pop | output | 1 | Pop strobe from the word FIFO |
| fifo_rdata | input | 32 | Head word of the FIFO (show-ahead) |
| fifo_empty | input | 1 | FIFO holds no word |
| rx_valid | input | 1 | Card offers a byte |
| rx_data | input | 8 | Byte from the card |
| rx_ready | output | 1 | Engine takes the offered byte |
| tx_valid | output | 1 | Engine offers a byte to the card |
| tx_data | output | 8 | Byte to the card |
| tx_ready | input | 1 | Card takes the offered byte |

## Verification
The checks assume the FIFO head word is valid whenever `fifo_empty` is low and that the FIFO never accepts a push while reporting full. The bench provides this by modelling the FIFO as a queue whose flags and head word are registered from its actual contents. The length register is never written in the same cycle as a control write that enables a transfer. The card side offers bytes only as a registered source and sink that change on clock edges, and `tx_ready` is toggled to exercise the hold rule.

// File: rtl/bpe_pkg.sv
package bpe_pkg;
    localparam int BPE_EN_BIT  = 0;
    localparam int BPE_DIR_BIT = 1;
    typedef enum logic {
        BPE_TO_CARD   = 1'b0,
        BPE_FROM_CARD = 1'b1
    } bpe_dir_e;
endpackage

// File: rtl/bpe_ctrl.sv
module bpe_ctrl
    import bpe_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int CTL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             len_we,
    input  logic [CNT_W-1:0] len_wdata,
    input  logic             stat_clr,
    input  logic             byte_moved,
    input  logic             fifo_empty,
    input  logic             tx_idle,
    output logic [CTL_W-1:0] ctl_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             load,
    output logic             data_end,
    output logic             blk_end
);
    typedef struct packed {
        logic [CTL_W-1:0] ctl;
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] cnt;
        logic             dend;
        logic             bend;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  drained;

    always_comb begin
        st_d    = st_q;
        load    = ctl_we && ctl_wdata[BPE_EN_BIT];
        drained = st_q.ctl[BPE_EN_BIT] && (st_q.cnt == '0);
        if (len_we) begin
            st_d.len = len_wdata;
        end
        if (ctl_we) begin
            st_d.ctl = ctl_wdata;
            if (load) begin
                st_d.cnt = st_q.len;
            end
        end else begin
            if (byte_moved) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
            if (drained && fifo_empty && tx_idle) begin
                st_d.ctl[BPE_EN_BIT] = 1'b0;
            end
        end
        if (stat_clr) begin
            st_d.dend = 1'b0;
            st_d.bend = 1'b0;
        end else if (drained) begin
            st_d.dend = 1'b1;
            st_d.bend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_q    = st_q.ctl;
    assign cnt_q    = st_q.cnt;
    assign data_end = st_q.dend;
    assign blk_end  = st_q.bend;

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ((cnt_q == $past(cnt_q)) || ((cnt_q + 1'b1) == $past(cnt_q))));
    // R7
    move_needs_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_moved |-> (cnt_q != '0));
    // R9
    en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ctl_q[BPE_EN_BIT]) && !$past(ctl_we)) |-> (($past(cnt_q) == '0) && $past(fifo_empty)));
    // R8
    end_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_end && !stat_clr) |=> data_end);
endmodule

// File: rtl/bpe_pack.sv
module bpe_pack #(
    parameter int BYTE_W     = 8,
    parameter int WORD_BYTES = 4,
    parameter int CNT_W      = 16,
    localparam int WORD_W    = BYTE_W * WORD_BYTES,
    localparam int LANE_W    = $clog2(WORD_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              load,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              fifo_full,
    output logic              rx_ready,
    output logic              take,
    output logic              fifo_push,
    output logic [WORD_W-1:0] fifo_wdata
);
    typedef struct packed {
        logic [LANE_W-1:0] pos;
        logic [WORD_W-1:0] acc;
    } pack_t;

    pack_t             st_d, st_q;
    logic [WORD_W-1:0] merged;
    logic              last;

    always_comb begin
        st_d     = st_q;
        rx_ready = run && (cnt_q != '0) && !fifo_full;
        take     = rx_ready && rx_valid;
        merged   = st_q.acc;
        for (int b = 0; b < WORD_BYTES; b++) begin
            if (st_q.pos == LANE_W'(b)) begin
                merged[b*BYTE_W +: BYTE_W] = rx_data;
            end
        end
        last       = take && ((st_q.pos == LANE_W'(WORD_BYTES - 1)) || (cnt_q == CNT_W'(1)));
        fifo_push  = last;
        fifo_wdata = last ? merged : '0;
        if (load) begin
            st_d = '0;
        end else if (take) begin
            if (last) begin
                st_d = '0;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
                st_d.acc = merged;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5
    push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !fifo_full);
    // R5
    ready_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> (cnt_q != '0));
endmodule

// File: rtl/bpe_unpack.sv
module bpe_unpack #(
    parameter int BYTE_W     = 8,
    parameter int WORD_BYTES = 4,
    parameter int CNT_W      = 16,
    localparam int WORD_W    = BYTE_W * WORD_BYTES,
    localparam int LANE_W    = $clog2(WORD_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              load,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_rdata,
    input  logic              tx_ready,
    output logic              fifo_pop,
    output logic              take,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_idle
);
    typedef struct packed {
        logic [LANE_W-1:0] pos;
        logic [WORD_W-1:0] hold;
        logic              vld;
        logic [BYTE_W-1:0] dat;
    } unpack_t;

    unpack_t           st_d, st_q;
    logic              need_word;
    logic              slot_free;
    logic [WORD_W-1:0] src;
    logic [BYTE_W-1:0] lane_byte;

    always_comb begin
        st_d      = st_q;
        need_word = (st_q.pos == '0);
        slot_free = !st_q.vld || tx_ready;
        take      = run && (cnt_q != '0) && slot_free && (!need_word || !fifo_empty);
        fifo_pop  = take && need_word;
        src       = need_word ? fifo_rdata : st_q.hold;
        lane_byte = '0;
        for (int b = 0; b < WORD_BYTES; b++) begin
            if (st_q.pos == LANE_W'(b)) begin
                lane_byte = src[b*BYTE_W +: BYTE_W];
            end
        end
        if (load) begin
            st_d.pos = '0;
            st_d.vld = 1'b0;
        end else if (take) begin
            st_d.vld  = 1'b1;
            st_d.dat  = lane_byte;
            st_d.hold = src;
            st_d.pos  = (st_q.pos == LANE_W'(WORD_BYTES - 1)) ? '0 : st_q.pos + 1'b1;
        end else if (st_q.vld && tx_ready) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_valid = st_q.vld;
    assign tx_data  = st_q.dat;
    assign tx_idle  = !st_q.vld;

    // R6
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !load) |=> (tx_valid && $stable(tx_data)));
    // R6
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);
endmodule

// File: rtl/bytepack_engine.sv
module bytepack_engine
    import bpe_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int WORD_BYTES = 4,
    parameter int CNT_W      = 16,
    parameter int CTL_W      = 8,
    localparam int WORD_W    = BYTE_W * WORD_BYTES,
    localparam int LANE_SH   = $clog2(WORD_BYTES),
    localparam int WC_W      = CNT_W - LANE_SH + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              len_we,
    input  logic [CNT_W-1:0]  len_wdata,
    input  logic              stat_clr,
    output logic [CTL_W-1:0]  ctl_rdata,
    output logic [CNT_W-1:0]  byte_cnt,
    output logic [WC_W-1:0]   word_cnt,
    output logic              data_end,
    output logic              blk_end,
    output logic              fifo_push,
    output logic [WORD_W-1:0] fifo_wdata,
    input  logic              fifo_full,
    output logic              fifo_pop,
    input  logic [WORD_W-1:0] fifo_rdata,
    input  logic              fifo_empty,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready
);
    logic [CTL_W-1:0] ctl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             load;
    logic             rx_take, tx_take, tx_idle;
    logic             run_rx, run_tx;
    logic [CNT_W:0]   cnt_round;
    bpe_dir_e         dir;

    bpe_ctrl #(.CNT_W(CNT_W), .CTL_W(CTL_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_wdata),
        .len_we     (len_we),
        .len_wdata  (len_wdata),
        .stat_clr   (stat_clr),
        .byte_moved (rx_take || tx_take),
        .fifo_empty (fifo_empty),
        .tx_idle    (tx_idle),
        .ctl_q      (ctl_q),
        .cnt_q      (cnt_q),
        .load       (load),
        .data_end   (data_end),
        .blk_end    (blk_end)
    );

    assign dir    = bpe_dir_e'(ctl_q[BPE_DIR_BIT]);
    assign run_rx = ctl_q[BPE_EN_BIT] && !ctl_we && (dir == BPE_FROM_CARD);
    assign run_tx = ctl_q[BPE_EN_BIT] && !ctl_we && (dir == BPE_TO_CARD);

    bpe_pack #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES), .CNT_W(CNT_W)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_rx),
        .load       (load),
        .cnt_q      (cnt_q),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .fifo_full  (fifo_full),
        .rx_ready   (rx_ready),
        .take       (rx_take),
        .fifo_push  (fifo_push),
        .fifo_wdata (fifo_wdata)
    );

    bpe_unpack #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES), .CNT_W(CNT_W)) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_tx),
        .load       (load),
        .cnt_q      (cnt_q),
        .fifo_empty (fifo_empty),
        .fifo_rdata (fifo_rdata),
        .tx_ready   (tx_ready),
        .fifo_pop   (fifo_pop),
        .take       (tx_take),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_idle    (tx_idle)
    );

    assign cnt_round = {1'b0, cnt_q} + (CNT_W+1)'(WORD_BYTES - 1);
    assign word_cnt  = cnt_round[CNT_W:LANE_SH];
    assign ctl_rdata = ctl_q;
    assign byte_cnt  = cnt_q;

    // R7
    one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_take && tx_take));
endmodule

// File: tb/bytepack_engine_tb.sv
`timescale 1ns/1ps
module bytepack_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic        len_we = 1'b0;
    logic [15:0] len_wdata = '0;
    logic        stat_clr = 1'b0;
    logic [7:0]  ctl_rdata;
    logic [15:0] byte_cnt;
    logic [14:0] word_cnt;
    logic        data_end, blk_end;
    logic        fifo_push, fifo_pop;
    logic [31:0] fifo_wdata;
    logic        fifo_full = 1'b0;
    logic        fifo_empty = 1'b1;
    logic [31:0] fifo_rdata = '0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [31:0] fq[$];
    logic        force_full = 1'b0;
    logic        tb_flush = 1'b0;
    logic [7:0]  rx_bytes [0:63];
    int          rx_idx = 0;
    int          rx_total = 0;
    logic        rx_en = 1'b0;
    logic [7:0]  tx_got [0:15];
    int          tx_n = 0;
    logic        tx_stall = 1'b0;
    logic        tgl = 1'b0;

    always #10 clk = ~clk;

    bytepack_engine u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .len_we(len_we), .len_wdata(len_wdata), .stat_clr(stat_clr),
        .ctl_rdata(ctl_rdata), .byte_cnt(byte_cnt), .word_cnt(word_cnt),
        .data_end(data_end), .blk_end(blk_end), .fifo_push(fifo_push),
        .fifo_wdata(fifo_wdata), .fifo_full(fifo_full), .fifo_pop(fifo_pop),
        .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready)
    );

    // word FIFO model with registered flags and head word
    always @(posedge clk) begin
        logic [31:0] gone;
        if (fifo_push) fq.push_back(fifo_wdata);
        if (fifo_pop && fq.size() > 0) gone = fq.pop_front();
        if (tb_flush) fq.delete();
        fifo_empty <= (fq.size() == 0);
        fifo_full  <= force_full || (fq.size() >= 16);
        fifo_rdata <= (fq.size() > 0) ? fq[0] : 32'h0;
    end

    // card byte source
    always @(posedge clk) begin
        if (rx_valid && rx_ready) rx_idx = rx_idx + 1;
        rx_valid <= rx_en && (rx_idx < rx_total);
        rx_data  <= rx_bytes[rx_idx[5:0]];
    end

    // card byte sink
    always @(posedge clk) begin
        tgl <= ~tgl;
        if (tx_valid && tx_ready) begin
            tx_got[tx_n[3:0]] = tx_data;
            tx_n = tx_n + 1;
        end
    end
    assign tx_ready = tx_stall ? tgl : 1'b1;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 100000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_len(input logic [15:0] v);
        @(negedge clk); len_we = 1'b1; len_wdata = v;
        @(negedge clk); len_we = 1'b0;
    endtask

    // starts the control write at the current negedge, returns one cycle later
    task automatic write_ctl(input logic [7:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic clear_status();
        stat_clr = 1'b1; @(negedge clk); stat_clr = 1'b0;
    endtask

    task automatic flush_fifo();
        tb_flush = 1'b1; @(negedge clk); tb_flush = 1'b0;
    endtask

    task automatic wait_cnt(input logic [15:0] v);
        for (int i = 0; i < 500; i++) begin
            if (byte_cnt == v) break;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 500; i++) begin
            if (ctl_rdata[0] == 1'b0) break;
            @(negedge clk);
        end
    endtask

    task automatic arm_source(input logic [7:0] base, input int total);
        for (int i = 0; i < 64; i++) rx_bytes[i] = base + 8'(i);
        rx_idx = 0; rx_total = total; rx_en = 1'b1;
    endtask

    task automatic t_reset();
        check("R1 ctl", 32'(ctl_rdata), 32'h0);
        check("R1 cnt", 32'(byte_cnt), 32'h0);
        check("R1 words", 32'(word_cnt), 32'h0);
        check("R1 flags", {30'h0, data_end, blk_end}, 32'h0);
        check("R1 strobes", {28'h0, tx_valid, rx_ready, fifo_push, fifo_pop}, 32'h0);
    endtask

    task automatic t_read_full();
        set_len(16'd8);
        arm_source(8'h10, 8);
        write_ctl(8'h03);
        check("R2 load", 32'(byte_cnt), 32'd8);
        check("R10 words8", 32'(word_cnt), 32'd2);
        check("R2 readback", 32'(ctl_rdata), 32'h03);
        ticks(3);
        check("R7 rate", 32'(byte_cnt), 32'd5);
        check("R10 words5", 32'(word_cnt), 32'd2);
        wait_cnt(16'd0);
        ticks(2);
        check("R3 count", fq.size(), 32'd2);
        if (fq.size() == 2) begin
            check("R3 word0", fq[0], 32'h13121110);
            check("R3 word1", fq[1], 32'h17161514);
        end
        check("R8 end", {30'h0, data_end, blk_end}, 32'h3);
        check("R9 held", 32'(ctl_rdata), 32'h03);
        check("R5 done", 32'(rx_ready), 32'h0);
        rx_en = 1'b0;
        flush_fifo();
        ticks(2);
        check("R9 selfclr", 32'(ctl_rdata), 32'h02);
        clear_status();
        check("R8 clr", {30'h0, data_end, blk_end}, 32'h0);
    endtask

    task automatic t_read_partial();
        set_len(16'd6);
        arm_source(8'h20, 6);
        write_ctl(8'h03);
        check("R10 words6", 32'(word_cnt), 32'd2);
        wait_cnt(16'd0);
        ticks(2);
        check("R4 count", fq.size(), 32'd2);
        if (fq.size() == 2) begin
            check("R3 word0", fq[0], 32'h23222120);
            check("R4 partial", fq[1], 32'h00002524);
        end
        rx_en = 1'b0;
        flush_fifo(); ticks(2); clear_status();
    endtask

    task automatic t_read_stall();
        set_len(16'd4);
        arm_source(8'h30, 6);
        force_full = 1'b1;
        write_ctl(8'h03);
        ticks(5);
        check("R5 stall cnt", 32'(byte_cnt), 32'd4);
        check("R5 stall rdy", 32'(rx_ready), 32'h0);
        force_full = 1'b0;
        wait_cnt(16'd0);
        ticks(4);
        check("R5 no extra", rx_idx, 32'd4);
        check("R3 one word", fq.size(), 32'd1);
        if (fq.size() == 1) check("R3 word", fq[0], 32'h33323130);
        rx_en = 1'b0;
        flush_fifo(); ticks(2); clear_status();
    endtask

    task automatic t_disable();
        set_len(16'd8);
        arm_source(8'h40, 3);
        write_ctl(8'h03);
        wait_cnt(16'd5);
        write_ctl(8'h0E);
        rx_total = 8;
        ticks(5);
        check("R11 cnt kept", 32'(byte_cnt), 32'd5);
        check("R11 no take", 32'(rx_ready), 32'h0);
        check("R2 mode bits", 32'(ctl_rdata), 32'h0E);
        check("R11 no push", fq.size(), 32'd0);
        check("R11 no end", 32'(data_end), 32'h0);
        rx_en = 1'b0;
        ticks(1);
    endtask

    task automatic t_write_stream();
        fq.push_back(32'hA3A2A1A0);
        fq.push_back(32'hB3B2B1B0);
        tx_n = 0; tx_stall = 1'b1;
        set_len(16'd7);
        write_ctl(8'h01);
        wait_idle();
        ticks(1);
        check("R6 count", tx_n, 32'd7);
        for (int i = 0; i < 7; i++) begin
            logic [7:0] e;
            e = (i < 4) ? (8'hA0 + 8'(i)) : (8'hB0 + 8'(i - 4));
            check("R6 byte order", 32'(tx_got[i]), 32'(e));
        end
        check("R6 drained", fq.size(), 32'd0);
        check("R9 write idle", 32'(ctl_rdata), 32'h00);
        check("R8 write end", {30'h0, data_end, blk_end}, 32'h3);
        tx_stall = 1'b0;
        clear_status();
    endtask

    task automatic t_write_short();
        fq.push_back(32'hC3C2C1C0);
        fq.push_back(32'hD3D2D1D0);
        tx_n = 0;
        set_len(16'd4);
        write_ctl(8'h01);
        wait_cnt(16'd0);
        ticks(4);
        check("R6 short count", tx_n, 32'd4);
        for (int i = 0; i < 4; i++) check("R6 short byte", 32'(tx_got[i]), 32'hC0 + i);
        check("R6 one pop", fq.size(), 32'd1);
        check("R9 stays on", 32'(ctl_rdata), 32'h01);
        check("R6 no pending", 32'(tx_valid), 32'h0);
        flush_fifo();
        ticks(2);
        check("R9 off after drain", 32'(ctl_rdata), 32'h00);
        clear_status();
    endtask

    task automatic t_zero_len();
        set_len(16'd0);
        write_ctl(8'h01);
        @(negedge clk);
        check("R9 zero len", 32'(ctl_rdata), 32'h00);
        check("R8 zero len", {30'h0, data_end, blk_end}, 32'h3);
        check("R10 zero", 32'(word_cnt), 32'd0);
        clear_status();
    endtask

    initial begin
        ticks(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_full();
        t_read_partial();
        t_read_stall();
        t_disable();
        t_write_stream();
        t_write_short();
        t_zero_len();
        ticks(2);
        summary();
        $finish;
    end
endmodule